// File: doc/BRIEF.md
# Packet UART Transmitter with Burst Queue

This block sends whole packets over an asynchronous serial line. A host first loads the payload as 32-bit words into a data queue. It then writes each packet's byte length into a separate length queue. Each non-zero length entry makes the block shift that many bytes out of the data queue. A packet always consumes whole words, so the unused high bytes of its final word are thrown away.

Packets queued back to back form a burst. Between packets the line rests high for a programmable number of bit times. The block can also steer the enable pin of an external RS-422/485 line driver. The host can hold that pin on permanently. In the automatic mode the block raises it a programmable number of clocks before the first start bit of a burst, and drops it one bit time after the last stop bit. A status word reports activity, queue occupancy, the programmed settings and a sticky queue-overrun flag. The bit period comes from a divider input given in clocks per bit.

Top module: `pkt_uart_tx`

## Requirements
- R1: Each byte goes out as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts `bit_div` clocks, and a `bit_div` of 0 behaves as 1. Whenever no byte is being shifted, `txd` is high.
- R2: Payload words are written with `wr_sel` = 0. The bytes of a word are sent from bits 7:0 up to bits 31:24. A packet of n bytes consumes ceil(n/4) words. The unused upper bytes of its last word are discarded, so the next packet starts on a fresh word.
- R3: A write with `wr_sel` = 1 pushes `wr_data[7:0]` into a length queue of `CNT_DEPTH` entries. The head entry is taken in the clock after it becomes visible, provided the block is idle and the data queue is not empty. That entry's first start bit then begins on the next clock. An entry of 0 is removed and sends nothing.
- R4: When the last stop bit of a packet ends and another length is queued, the line stays high for gap×`bit_div` clocks plus one clock before the next start bit. The gap is the field in status bits 15:8.
- R5: Status bit 7 (busy) is set while the length queue is non-empty, a byte is shifting, a gap is running, the lead time is running, or the one-bit trailing time after a burst is running. It is clear otherwise.
- R6: A write with `wr_sel` = 2 sets the gap from `wr_data[15:8]`, the forced enable from bit 6, the automatic enable from bit 5 and the lead time from bits 3:0. These fields read back at the same positions of `status`. Status bits 20:16 give the length-queue occupancy and bit 21 is set while the data queue holds a word. All other status bits read 0, and every field is 0 after reset.
- R7: While the forced-enable field is 1, `drv_en` is high.
- R8: With automatic enable set, `drv_en` rises as a packet leaves idle, exactly lead-time clocks before its first start bit. When the lead time is 0, it rises in the same clock as the start bit. It stays high through gaps within a burst. It falls one bit time after the last stop bit once the length queue is empty.
- R9: A length write that finds the queue full, in a clock where no entry is being removed, is dropped and sets status bit 4. The flag stays set until a `wr_sel` = 2 write with bit 4 = 1 or reset clears it.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_div | input | DIV_W | Clocks per serial bit (0 acts as 1) |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 data word, 1 packet length, 2 mode |
| wr_data | input | 32 | Write value |
| status | output | 32 | Status and mode read-back word |
| txd | output | 1 | Serial output, idle high |
| drv_en | output | 1 | External line-driver enable |

## Verification
The bench builds the block with a 16-word data queue, a 4-entry length queue and an 8-bit divider. The shallow length queue lets a short run of length writes reach the overrun and sticky-flag cases. The bit period is switched between 4, 1 and 0 clocks. A bit period of 1 covers the tightest timing, where a byte ends and the next one loads in adjacent clocks. A bit period of 0 checks the clamp to 1. Bursts with gaps of 0, 2 and 5 bit times, lead times of 0, 3 and 15, forced enable, a zero-length entry and packets of 1 to 8 bytes together reach every word-boundary and discard case.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int LEN_W      = 8;
    localparam int FRAME_BITS = 10;
    localparam int LEAD_W     = 4;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_MODE  = 2'd2
    } wr_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_GAP   = 3'd3,
        ST_TAIL  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [7:0]        gap_bits;
        logic              force_de;
        logic              auto_de;
        logic [LEAD_W-1:0] lead_clks;
    } mode_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic [1:0] sel);
        return w[{sel, 3'b000} +: BYTE_W];
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_byte(input logic [BYTE_W-1:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop, full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/pkt_tx_regs.sv
module pkt_tx_regs
    import pkt_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [7:0]        gap_in,
    input  logic              force_in,
    input  logic              auto_in,
    input  logic              clr_in,
    input  logic [LEAD_W-1:0] lead_in,
    input  logic              overrun_evt,
    output mode_t             mode_q,
    output logic              err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q.gap_bits  <= gap_in;
            mode_q.force_de  <= force_in;
            mode_q.auto_de   <= auto_in;
            mode_q.lead_clks <= lead_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   err_q <= 1'b0;
        else if (overrun_evt)      err_q <= 1'b1;
        else if (mode_wr && clr_in) err_q <= 1'b0;
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(mode_wr && clr_in)) |=> err_q);

    a_r9_err_on_overrun: assert property (@(posedge clk) disable iff (rst)
        overrun_evt |=> err_q);

endmodule

// File: rtl/pkt_tx_engine.sv
module pkt_tx_engine
    import pkt_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic [7:0]        gap_bits,
    input  logic              auto_de,
    input  logic [LEAD_W-1:0] lead_clks,
    input  logic [LEN_W-1:0]  cnt_head,
    input  logic              cnt_empty,
    input  logic [WORD_W-1:0] data_head,
    input  logic              data_empty,
    output logic              cnt_pop,
    output logic              data_pop,
    output logic              txd,
    output logic              drv_on,
    output logic              active
);

    tx_state_e             st_q, st_n;
    logic [DIV_W-1:0]      tmr_q, tmr_n, per_m1;
    logic [3:0]            bit_q, bit_n;
    logic [FRAME_BITS-1:0] sh_q, sh_n;
    logic [1:0]            sel_q, sel_n, load_sel;
    logic [LEN_W-1:0]      rem_q, rem_n, load_rem;
    logic [7:0]            gcnt_q, gcnt_n;
    logic                  drv_q, drv_n, load;

    assign per_m1 = (bit_div == '0) ? '0 : bit_div - 1'b1;

    always_comb begin
        st_n     = st_q;
        tmr_n    = tmr_q;
        bit_n    = bit_q;
        sh_n     = sh_q;
        sel_n    = sel_q;
        rem_n    = rem_q;
        gcnt_n   = gcnt_q;
        drv_n    = drv_q;
        cnt_pop  = 1'b0;
        data_pop = 1'b0;
        load     = 1'b0;
        load_sel = sel_q;
        load_rem = rem_q;

        case (st_q)
            ST_IDLE: begin
                if (cnt_empty) begin
                    drv_n = 1'b0;
                end else if (cnt_head == '0) begin
                    cnt_pop = 1'b1;
                end else if (!data_empty) begin
                    cnt_pop = 1'b1;
                    drv_n   = drv_q | auto_de;
                    if (auto_de && !drv_q && (lead_clks != '0)) begin
                        st_n  = ST_LEAD;
                        tmr_n = DIV_W'(lead_clks) - 1'b1;
                        rem_n = cnt_head;
                        sel_n = 2'd0;
                    end else begin
                        load     = 1'b1;
                        load_sel = 2'd0;
                        load_rem = cnt_head;
                    end
                end
            end
            ST_LEAD: begin
                if (tmr_q == '0) load = 1'b1;
                else             tmr_n = tmr_q - 1'b1;
            end
            ST_SHIFT: begin
                if (tmr_q != '0) begin
                    tmr_n = tmr_q - 1'b1;
                end else if (bit_q != 4'(FRAME_BITS - 1)) begin
                    sh_n  = {1'b1, sh_q[FRAME_BITS-1:1]};
                    bit_n = bit_q + 1'b1;
                    tmr_n = per_m1;
                end else if (rem_q != '0) begin
                    load = 1'b1;
                end else if (!cnt_empty) begin
                    if (gap_bits != '0) begin
                        st_n   = ST_GAP;
                        gcnt_n = gap_bits - 1'b1;
                        tmr_n  = per_m1;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else begin
                    st_n  = ST_TAIL;
                    tmr_n = per_m1;
                end
            end
            ST_GAP: begin
                if (tmr_q != '0) begin
                    tmr_n = tmr_q - 1'b1;
                end else if (gcnt_q != '0) begin
                    gcnt_n = gcnt_q - 1'b1;
                    tmr_n  = per_m1;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            ST_TAIL: begin
                if (tmr_q != '0) begin
                    tmr_n = tmr_q - 1'b1;
                end else begin
                    st_n  = ST_IDLE;
                    drv_n = 1'b0;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (load) begin
            sh_n     = frame_byte(pick_byte(data_head, load_sel));
            bit_n    = 4'd0;
            tmr_n    = per_m1;
            st_n     = ST_SHIFT;
            sel_n    = load_sel + 2'd1;
            rem_n    = load_rem - 1'b1;
            data_pop = (load_sel == 2'd3) || (load_rem == LEN_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            tmr_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '1;
            sel_q  <= '0;
            rem_q  <= '0;
            gcnt_q <= '0;
            drv_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            tmr_q  <= tmr_n;
            bit_q  <= bit_n;
            sh_q   <= sh_n;
            sel_q  <= sel_n;
            rem_q  <= rem_n;
            gcnt_q <= gcnt_n;
            drv_q  <= drv_n;
        end
    end

    assign txd    = (st_q == ST_SHIFT) ? sh_q[0] : 1'b1;
    assign drv_on = drv_q;
    assign active = (st_q != ST_IDLE);

    a_r1_stop_bit_high: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHIFT && bit_q == 4'(FRAME_BITS - 1)) |-> sh_q[0]);

    a_r4_gap_follows_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == ST_GAP) |-> $past(st_q == ST_SHIFT));

    a_r8_lead_drives_pin: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LEAD) |-> drv_q);

endmodule

// File: rtl/pkt_uart_tx.sv
module pkt_uart_tx
    import pkt_tx_pkg::*;
#(
    parameter int DATA_DEPTH = 64,
    parameter int CNT_DEPTH  = 16,
    parameter int DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output logic [31:0]       status,
    output logic              txd,
    output logic              drv_en
);
    localparam int CL_W = $clog2(CNT_DEPTH + 1);
    localparam int DL_W = $clog2(DATA_DEPTH + 1);

    logic                data_push, cnt_push, mode_wr;
    logic                data_pop, cnt_pop, data_empty, cnt_empty;
    logic [WORD_W-1:0]   data_head;
    logic [LEN_W-1:0]    cnt_head;
    logic [DL_W-1:0]     data_level;
    logic [CL_W-1:0]     cnt_level;
    logic [4:0]          lvl5;
    logic                overrun, err_q, drv_on, active, busy;
    mode_t               mode_q;

    assign data_push = wr_en && (wr_sel == SEL_DATA);
    assign cnt_push  = wr_en && (wr_sel == SEL_COUNT);
    assign mode_wr   = wr_en && (wr_sel == SEL_MODE);
    assign overrun   = cnt_push && (cnt_level == CL_W'(CNT_DEPTH)) && !cnt_pop;

    pkt_tx_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) u_data_q (
        .clk(clk), .rst(rst), .push(data_push), .din(wr_data), .pop(data_pop),
        .head(data_head), .level(data_level), .empty(data_empty)
    );

    pkt_tx_fifo #(.W(LEN_W), .DEPTH(CNT_DEPTH)) u_len_q (
        .clk(clk), .rst(rst), .push(cnt_push), .din(wr_data[LEN_W-1:0]), .pop(cnt_pop),
        .head(cnt_head), .level(cnt_level), .empty(cnt_empty)
    );

    pkt_tx_regs u_regs (
        .clk(clk), .rst(rst), .mode_wr(mode_wr),
        .gap_in(wr_data[15:8]), .force_in(wr_data[6]), .auto_in(wr_data[5]),
        .clr_in(wr_data[4]), .lead_in(wr_data[LEAD_W-1:0]),
        .overrun_evt(overrun), .mode_q(mode_q), .err_q(err_q)
    );

    pkt_tx_engine #(.DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst(rst), .bit_div(bit_div),
        .gap_bits(mode_q.gap_bits), .auto_de(mode_q.auto_de), .lead_clks(mode_q.lead_clks),
        .cnt_head(cnt_head), .cnt_empty(cnt_empty),
        .data_head(data_head), .data_empty(data_empty),
        .cnt_pop(cnt_pop), .data_pop(data_pop),
        .txd(txd), .drv_on(drv_on), .active(active)
    );

    generate
        if (CL_W >= 5) begin : g_lvl_trunc
            assign lvl5 = cnt_level[4:0];
        end else begin : g_lvl_pad
            assign lvl5 = {{(5 - CL_W){1'b0}}, cnt_level};
        end
    endgenerate

    assign busy   = !cnt_empty || active;
    assign drv_en = mode_q.force_de || drv_on;
    assign status = {10'd0, (data_level != '0), lvl5, mode_q.gap_bits, busy,
                     mode_q.force_de, mode_q.auto_de, err_q, mode_q.lead_clks};

    a_r5_busy_while_low: assert property (@(posedge clk) disable iff (rst)
        !txd |-> status[7]);

    a_r3_len_pop_needs_entry: assert property (@(posedge clk) disable iff (rst)
        cnt_pop |-> (cnt_level != '0));

endmodule

// File: tb/sim_pkt_uart_tx.sv
`timescale 1ns/1ps
module sim_pkt_uart_tx;
    localparam int DATA_DEPTH = 16;
    localparam int CNT_DEPTH  = 4;
    localparam int DIV_W      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bit_div = 8'd4;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        txd, drv_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 0;

    pkt_uart_tx #(.DATA_DEPTH(DATA_DEPTH), .CNT_DEPTH(CNT_DEPTH), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .bit_div(bit_div), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status(status), .txd(txd), .drv_en(drv_en)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st, m_tmr, m_bit, m_sh, m_sel, m_rem, m_gcnt, m_drv;
    int m_gap, m_force, m_auto, m_lead, m_err;
    logic [31:0] dq[$];
    int cq[$];
    int eb[$];
    int n_now, dsz, csz, was;
    bit pop_c, pop_d;

    task mload(input int s, input int r);
        int b;
        b = int'((dq[0] >> (8 * s)) & 32'hFF);
        m_sh = 512 | (b << 1);
        m_bit = 0;
        m_tmr = n_now - 1;
        m_st = 2;
        m_sel = (s + 1) % 4;
        m_rem = r - 1;
        if (s == 3 || r == 1) pop_d = 1;
        eb.push_back(b);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0; m_tmr = 0; m_bit = 0; m_sh = 1023; m_sel = 0; m_rem = 0;
            m_gcnt = 0; m_drv = 0; m_gap = 0; m_force = 0; m_auto = 0; m_lead = 0; m_err = 0;
            dq.delete(); cq.delete(); eb.delete();
        end else begin
            n_now = (bit_div == 0) ? 1 : int'(bit_div);
            pop_c = 0; pop_d = 0;
            dsz = dq.size(); csz = cq.size();
            case (m_st)
                0: begin
                    if (csz == 0) m_drv = 0;
                    else if (cq[0] == 0) pop_c = 1;
                    else if (dsz != 0) begin
                        pop_c = 1;
                        was = m_drv;
                        m_drv = m_drv | m_auto;
                        if (m_auto != 0 && was == 0 && m_lead != 0) begin
                            m_st = 1; m_tmr = m_lead - 1; m_rem = cq[0]; m_sel = 0;
                        end else mload(0, cq[0]);
                    end
                end
                1: if (m_tmr == 0) mload(m_sel, m_rem); else m_tmr--;
                2: begin
                    if (m_tmr != 0) m_tmr--;
                    else if (m_bit != 9) begin m_sh = (m_sh >> 1) | 512; m_bit++; m_tmr = n_now - 1; end
                    else if (m_rem != 0) mload(m_sel, m_rem);
                    else if (csz != 0) begin
                        if (m_gap != 0) begin m_st = 3; m_gcnt = m_gap - 1; m_tmr = n_now - 1; end
                        else m_st = 0;
                    end else begin m_st = 4; m_tmr = n_now - 1; end
                end
                3: begin
                    if (m_tmr != 0) m_tmr--;
                    else if (m_gcnt != 0) begin m_gcnt--; m_tmr = n_now - 1; end
                    else m_st = 0;
                end
                default: begin
                    if (m_tmr != 0) m_tmr--;
                    else begin m_st = 0; m_drv = 0; end
                end
            endcase
            if (pop_c) void'(cq.pop_front());
            if (pop_d) void'(dq.pop_front());
            if (wr_en) begin
                case (wr_sel)
                    2'd0: if (dsz < DATA_DEPTH || pop_d) dq.push_back(wr_data);
                    2'd1: if (csz < CNT_DEPTH || pop_c) cq.push_back(int'(wr_data[7:0])); else m_err = 1;
                    2'd2: begin
                        m_gap = int'(wr_data[15:8]); m_force = int'(wr_data[6]);
                        m_auto = int'(wr_data[5]); m_lead = int'(wr_data[3:0]);
                        if (wr_data[4]) m_err = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1 txd", {31'd0, txd}, (m_st == 2) ? (m_sh & 1) : 1);
            chk("R7/R8 drv_en", {31'd0, drv_en}, ((m_force | m_drv) != 0) ? 1 : 0);
            chk("R5 busy", {31'd0, status[7]}, (cq.size() != 0 || m_st != 0) ? 1 : 0);
            chk("R6 levels", {26'd0, status[21:16]}, ((dq.size() != 0) ? 32 : 0) | (cq.size() & 31));
            chk("R6 mode fields", {16'd0, status[15:8], 1'b0, status[6:5], 1'b0, status[3:0]},
                (m_gap << 8) | (m_force << 6) | (m_auto << 5) | m_lead);
            chk("R9 overrun flag", {31'd0, status[4]}, m_err);
            chk("R6 upper zero", {22'd0, status[31:22]}, 0);
        end
    end

    // independent line receiver
    int rx_t = 0, rx_byte = 0, rx_count = 0;
    bit rx_busy = 0;
    always @(negedge clk) begin
        int n;
        n = (bit_div == 0) ? 1 : int'(bit_div);
        if (rst) begin
            rx_busy = 0;
        end else if (!rx_busy) begin
            if (txd == 1'b0) begin rx_busy = 1; rx_t = 0; rx_byte = 0; end
        end else begin
            rx_t++;
            for (int i = 1; i <= 9; i++) begin
                if (rx_t == i * n + n / 2) begin
                    if (i <= 8) rx_byte = rx_byte | (int'(txd) << (i - 1));
                    else begin
                        chk("R1 stop bit", {31'd0, txd}, 1);
                        rx_busy = 0;
                        rx_count++;
                        if (eb.size() == 0) chk("R2 unexpected byte", rx_byte, 32'hFFFF);
                        else chk("R2 byte order", rx_byte, eb.pop_front());
                    end
                end
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_pkt(input int nbytes, input int seed);
        for (int w = 0; w < (nbytes + 3) / 4; w++) begin
            logic [31:0] word;
            word = '0;
            for (int k = 0; k < 4; k++) word[k*8 +: 8] = 8'((seed + (w * 4 + k) * 7) & 255);
            wr(2'd0, word);
        end
        wr(2'd1, 32'(nbytes));
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while ((m_st != 0 || cq.size() != 0 || m_drv != 0 || rx_busy) && guard < 20000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 reset status", status, 32'd0);
        chk("R1 reset txd", {31'd0, txd}, 1);
        chk("R8 reset drv_en", {31'd0, drv_en}, 0);
        cmp_on = 1;

        // R4 R8: auto enable, lead 3, gap 2, burst of two packets
        bit_div = 8'd4;
        wr(2'd2, 32'h0000_0223);
        send_pkt(5, 1);
        send_pkt(3, 8'h40);
        wait_idle();
        chk("R2 all bytes seen", eb.size(), 0);

        // R3: zero-length entry sends nothing
        snap = rx_count;
        wr(2'd1, 32'd0);
        repeat (20) @(negedge clk);
        chk("R3 zero length silent", rx_count, snap);
        chk("R3 zero entry removed", {27'd0, status[20:16]}, 0);
        wr(2'd2, 32'h0000_0020);
        send_pkt(1, 8'h80);
        wait_idle();

        // R7: forced enable, gap 0, one clock per bit
        bit_div = 8'd1;
        wr(2'd2, 32'h0000_0040);
        send_pkt(4, 8'h11);
        send_pkt(8, 8'h22);
        send_pkt(6, 8'h33);
        wait_idle();
        chk("R7 forced enable held", {31'd0, drv_en}, 1);

        // R1: divider 0 acts as 1, long lead and gap
        bit_div = 8'd0;
        wr(2'd2, 32'h0000_052F);
        send_pkt(2, 8'h55);
        send_pkt(7, 8'h66);
        wait_idle();

        // R9: overrun of the length queue
        bit_div = 8'd4;
        wr(2'd2, 32'h0000_0120);
        for (int p = 0; p < 6; p++) wr(2'd0, 32'hA0 + 32'(p));
        for (int p = 0; p < 6; p++) wr(2'd1, 32'd1);
        chk("R9 overrun set", {31'd0, status[4]}, 1);
        wr(2'd2, 32'h0000_0120);
        chk("R9 still sticky", {31'd0, status[4]}, 1);
        wr(2'd2, 32'h0000_0130);
        chk("R9 cleared", {31'd0, status[4]}, 0);
        wait_idle();
        wr(2'd1, 32'd1);
        wait_idle();
        chk("R2 data queue drained", {31'd0, status[21]}, 0);
        chk("R5 idle at end", {31'd0, status[7]}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule